// File: doc/BRIEF.md
# Per-Core Mailbox Interprocessor Interrupt Controller

This block lets the cores of a four-core cluster signal one another. Every core owns four 32-bit mailboxes. Any core may OR bits into any mailbox through that mailbox's set address, or knock bits out through its clear address. Reading the clear address returns the mailbox contents, so a sender can poll a target's mailbox until the target has emptied it. Mailbox 0 is used as a doorbell word with one bit per vector, and mailbox 3 carries a start address that releases a parked secondary core. To reach several cores, a sender issues one set-write per target core.

Each core has a control register whose low bits enable an interrupt for each of its mailboxes. The block drives one registered IRQ level per core. It also offers a per-core source register that shows which mailboxes are pending, so a handler can test for any mailbox interrupt with mask 0xF0. Two independent synchronous bus ports share the register file. Each access on a port carries the ID of the core that issues it, and a small alias window uses this ID so that a core can reach its own control and source registers without knowing its index.

Top module: `mbx_ipi_ctrl`

## Requirements
- R1: Byte address map. Set address of core c, mailbox m is 0x00+4*(4c+m). Clear/read address is 0x40+4*(4c+m). Control register of core c is at 0x80+4c and source register of core c is at 0xA0+4c. The requester's own source register is at 0xC0 and its own control register at 0xC4. Every other address, including unaligned ones, reads 0 and ignores writes.
- R2: After reset, all mailboxes, all enable bits and all IRQ outputs are 0.
- R3: A write to a set address ORs the write data into that mailbox, and bits that are already set stay set. Set-writes from both ports to one mailbox in the same cycle are merged by OR.
- R4: A write to a clear address clears every mailbox bit that is 1 in the write data and leaves the other bits unchanged.
- R5: Reading a clear address returns the mailbox's current contents, combinationally and before any write in the same cycle. Reading a set address returns 0.
- R6: Control register bits 3:0 hold the enables for mailboxes 0 to 3, and the upper bits read 0. If both ports write one core's control register in the same cycle, port 1 wins. Source register bits 7:4 show mailboxes 0 to 3 as pending (non-zero and enabled), and all other bits read 0.
- R7: irq_o[c] is a registered level. One cycle after a cycle in which some mailbox of core c is non-zero with its enable set, it is 1. Otherwise it is 0.
- R8: When a set and a clear reach the same mailbox in one cycle, the set wins for bits present in both.
- R9: The alias addresses 0xC0 and 0xC4 resolve to the core given by the access's requester ID, for both reads and writes.
- R10: A write changes only the one mailbox or control register it addresses. No other core's or mailbox's state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | NUM_PORTS (2) | Write strobe per port |
| bus_addr_i | input | NUM_PORTS×ADDR_W (2×8) | Byte address per port |
| bus_wdata_i | input | NUM_PORTS×DATA_W (2×32) | Write data per port |
| bus_req_core_i | input | NUM_PORTS×CORE_W (2×2) | Requesting core ID per port |
| bus_rdata_o | output | NUM_PORTS×DATA_W (2×32) | Combinational read data per port |
| irq_o | output | NUM_CORES (4) | Registered mailbox IRQ per core |

## Verification
On every cycle, assertions check the per-mailbox update rules: set bits appear, cleared bits vanish, set beats clear, and an untouched mailbox holds its value. They also check that each core's IRQ follows its pending state with one cycle of lag. The decoded address map, the read values of the control and source registers, the requester-ID alias, port priority on control writes, and the rule that a write does not disturb any other register are shown only by the bench. The bench sweeps every mailbox and every enable pattern against an arithmetic model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_CTRL,
    ACC_SRC
  } acc_kind_e;

  // pending field position inside the source register
  localparam int SRC_LSB = 4;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W = 8,
  parameter int CORE_W = 2,
  parameter int MBOX_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CORE_W-1:0] req_core_i,
  output mbx_pkg::acc_kind_e kind_o,
  output logic [CORE_W-1:0] core_o,
  output logic [MBOX_W-1:0] mbox_o
);
  import mbx_pkg::*;

  localparam int IDX_W   = CORE_W + MBOX_W;
  localparam int REG_LSB = IDX_W + 2;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] grp_pad;
  logic [1:0]       region;
  logic             aligned;
  logic             hi_zero;
  logic             pad_ok;

  assign idx     = addr_i[2 +: IDX_W];
  assign region  = addr_i[REG_LSB +: 2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign hi_zero = ((addr_i >> (REG_LSB + 2)) == '0);
  // register group: top index bit picks ctrl/src, core in low bits, rest must be 0
  assign grp_pad = idx & ~(IDX_W'(1) << (IDX_W - 1));
  assign pad_ok  = ((grp_pad >> CORE_W) == '0);

  always_comb begin
    kind_o = ACC_NONE;
    core_o = idx[MBOX_W +: CORE_W];
    mbox_o = idx[MBOX_W-1:0];
    if (aligned && hi_zero) begin
      case (region)
        2'd0: kind_o = ACC_SET;
        2'd1: kind_o = ACC_CLR;
        2'd2: begin
          if (pad_ok) begin
            kind_o = idx[IDX_W-1] ? ACC_SRC : ACC_CTRL;
            core_o = idx[CORE_W-1:0];
          end
        end
        default: begin
          if (idx[IDX_W-1:1] == '0) begin
            kind_o = idx[0] ? ACC_CTRL : ACC_SRC;
            core_o = req_core_i;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 2,
  parameter int MBOX_W    = 2,
  parameter int CORE_ID   = 0,
  parameter int MBOX_ID   = 0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_PORTS-1:0]                 we_i,
  input  mbx_pkg::acc_kind_e [NUM_PORTS-1:0]   kind_i,
  input  logic [NUM_PORTS-1:0][CORE_W-1:0]     core_i,
  input  logic [NUM_PORTS-1:0][MBOX_W-1:0]     mbox_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]                    val_o
);
  import mbx_pkg::*;

  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] set_m;
  logic [DATA_W-1:0] clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we_i[p] && core_i[p] == CORE_W'(CORE_ID) && mbox_i[p] == MBOX_W'(MBOX_ID)) begin
        if (kind_i[p] == ACC_SET) set_m = set_m | wdata_i[p];
        if (kind_i[p] == ACC_CLR) clr_m = clr_m | wdata_i[p];
      end
    end
  end

  // set applied after clear: set wins on overlap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= (val_q & ~clr_m) | set_m;
  end

  assign val_o = val_q;

  assert_set_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_m) |=> ((val_q & $past(set_m)) == $past(set_m)));

  assert_clear_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_m & ~set_m)) |=> ((val_q & $past(clr_m & ~set_m)) == '0));

  assert_set_beats_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_m & clr_m)) |=> ((val_q & $past(set_m & clr_m)) == $past(set_m & clr_m)));

  assert_untouched_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m == '0 && clr_m == '0) |=> $stable(val_q));

endmodule

// File: rtl/mbx_core_irq.sv
module mbx_core_irq #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_MBOX  = 4,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 2,
  parameter int CORE_ID   = 0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_PORTS-1:0]                 we_i,
  input  mbx_pkg::acc_kind_e [NUM_PORTS-1:0]   kind_i,
  input  logic [NUM_PORTS-1:0][CORE_W-1:0]     core_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wdata_i,
  input  logic [NUM_MBOX-1:0][DATA_W-1:0]      mbox_i,
  output logic [NUM_MBOX-1:0]                  en_o,
  output logic [NUM_MBOX-1:0]                  pend_o,
  output logic                                 irq_o
);
  import mbx_pkg::*;

  logic [NUM_MBOX-1:0] en_q;
  logic [NUM_MBOX-1:0] en_d;
  logic [NUM_MBOX-1:0] nz;
  logic                irq_q;

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_nz
    assign nz[m] = |mbox_i[m];
  end

  // later port overrides earlier one
  always_comb begin
    en_d = en_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we_i[p] && kind_i[p] == ACC_CTRL && core_i[p] == CORE_W'(CORE_ID))
        en_d = wdata_i[p][NUM_MBOX-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= |(nz & en_q);
    end
  end

  assign en_o   = en_q;
  assign pend_o = nz & en_q;
  assign irq_o  = irq_q;

  assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(nz & en_q)) |=> irq_q);

  assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(nz & en_q)) |=> !irq_q);

endmodule

// File: rtl/mbx_ipi_ctrl.sv
module mbx_ipi_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int NUM_MBOX  = 4,
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              bus_we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  bus_addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  bus_wdata_i,
  input  logic [NUM_PORTS-1:0][CORE_W-1:0]  bus_req_core_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_CORES-1:0]              irq_o
);
  import mbx_pkg::*;

  localparam int MBOX_W = $clog2(NUM_MBOX);

  acc_kind_e [NUM_PORTS-1:0]                      kind;
  logic [NUM_PORTS-1:0][CORE_W-1:0]               acc_core;
  logic [NUM_PORTS-1:0][MBOX_W-1:0]               acc_mbox;
  logic [NUM_CORES-1:0][NUM_MBOX-1:0][DATA_W-1:0] mbox_val;
  logic [NUM_CORES-1:0][NUM_MBOX-1:0]             en_q;
  logic [NUM_CORES-1:0][NUM_MBOX-1:0]             pend;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbx_decode #(
      .ADDR_W (ADDR_W),
      .CORE_W (CORE_W),
      .MBOX_W (MBOX_W)
    ) u_dec (
      .addr_i     (bus_addr_i[p]),
      .req_core_i (bus_req_core_i[p]),
      .kind_o     (kind[p]),
      .core_o     (acc_core[p]),
      .mbox_o     (acc_mbox[p])
    );
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
      mbx_cell #(
        .NUM_PORTS (NUM_PORTS),
        .DATA_W    (DATA_W),
        .CORE_W    (CORE_W),
        .MBOX_W    (MBOX_W),
        .CORE_ID   (c),
        .MBOX_ID   (m)
      ) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .kind_i  (kind),
        .core_i  (acc_core),
        .mbox_i  (acc_mbox),
        .wdata_i (bus_wdata_i),
        .val_o   (mbox_val[c][m])
      );
    end

    mbx_core_irq #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_MBOX  (NUM_MBOX),
      .DATA_W    (DATA_W),
      .CORE_W    (CORE_W),
      .CORE_ID   (c)
    ) u_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bus_we_i),
      .kind_i  (kind),
      .core_i  (acc_core),
      .wdata_i (bus_wdata_i),
      .mbox_i  (mbox_val[c]),
      .en_o    (en_q[c]),
      .pend_o  (pend[c]),
      .irq_o   (irq_o[c])
    );
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      bus_rdata_o[p] = '0;
      case (kind[p])
        ACC_CLR:  bus_rdata_o[p] = mbox_val[acc_core[p]][acc_mbox[p]];
        ACC_CTRL: bus_rdata_o[p][NUM_MBOX-1:0] = en_q[acc_core[p]];
        ACC_SRC:  bus_rdata_o[p][SRC_LSB +: NUM_MBOX] = pend[acc_core[p]];
        default:  bus_rdata_o[p] = '0;
      endcase
    end
  end

endmodule

// File: tb/tb_mbx_ipi_ctrl.sv
module tb_mbx_ipi_ctrl;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       bus_we_i = '0;
  logic [1:0][7:0]  bus_addr_i = '0;
  logic [1:0][31:0] bus_wdata_i = '0;
  logic [1:0][1:0]  bus_req_core_i = '0;
  logic [1:0][31:0] bus_rdata_o;
  logic [3:0]       irq_o;

  mbx_ipi_ctrl dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bus_we_i       (bus_we_i),
    .bus_addr_i     (bus_addr_i),
    .bus_wdata_i    (bus_wdata_i),
    .bus_req_core_i (bus_req_core_i),
    .bus_rdata_o    (bus_rdata_o),
    .irq_o          (irq_o)
  );

  always #5 clk_i = ~clk_i;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0] mb [4][4];
  logic [3:0]  en [4];
  logic [3:0]  irq_exp;

  function automatic logic [7:0] a_set(int c, int m); return 8'((c*4 + m)*4); endfunction
  function automatic logic [7:0] a_clr(int c, int m); return 8'(8'h40 + (c*4 + m)*4); endfunction
  function automatic logic [7:0] a_ctl(int c); return 8'(8'h80 + c*4); endfunction
  function automatic logic [7:0] a_src(int c); return 8'(8'hA0 + c*4); endfunction

  function automatic logic [31:0] src_exp(int c);
    logic [3:0] pv;
    for (int m = 0; m < 4; m++) pv[m] = (mb[c][m] != 0) && en[c][m];
    return {24'b0, pv, 4'b0};
  endfunction

  // model decode from the address map (R1): kind 0 none,1 set,2 clr,3 ctrl,4 src
  function automatic void dec(input logic [7:0] a, input logic [1:0] r,
                              output int k, output int c, output int m);
    k = 0; c = 0; m = 0;
    if (a[1:0] != 2'b00) return;
    case (a[7:6])
      2'd0: begin k = 1; c = int'(a[5:4]); m = int'(a[3:2]); end
      2'd1: begin k = 2; c = int'(a[5:4]); m = int'(a[3:2]); end
      2'd2: if (!a[4]) begin k = a[5] ? 4 : 3; c = int'(a[3:2]); end
      default: if (a[5:3] == 3'b000) begin k = a[2] ? 3 : 4; c = int'(r); end
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [3:0]  pre;
    logic [31:0] sm [4][4];
    logic [31:0] cm [4][4];
    int k, c, m;
    for (int ci = 0; ci < 4; ci++) begin
      pre[ci] = 1'b0;
      for (int mi = 0; mi < 4; mi++) begin
        if (mb[ci][mi] != 0 && en[ci][mi]) pre[ci] = 1'b1;
        sm[ci][mi] = '0;
        cm[ci][mi] = '0;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    for (int p = 0; p < 2; p++) begin
      if (bus_we_i[p]) begin
        dec(bus_addr_i[p], bus_req_core_i[p], k, c, m);
        if (k == 1) sm[c][m] = sm[c][m] | bus_wdata_i[p];
        if (k == 2) cm[c][m] = cm[c][m] | bus_wdata_i[p];
        if (k == 3) en[c] = bus_wdata_i[p][3:0];
      end
    end
    for (int ci = 0; ci < 4; ci++)
      for (int mi = 0; mi < 4; mi++)
        mb[ci][mi] = (mb[ci][mi] & ~cm[ci][mi]) | sm[ci][mi];
    bus_we_i = '0;
    irq_exp = pre;
    check("R7 irq level", {28'b0, irq_o}, {28'b0, irq_exp});
  endtask

  task automatic put(int p, logic [7:0] a, logic [31:0] d, logic [1:0] r);
    bus_addr_i[p]     = a;
    bus_wdata_i[p]    = d;
    bus_req_core_i[p] = r;
    bus_we_i[p]       = 1'b1;
  endtask

  task automatic rd(int p, logic [7:0] a, logic [1:0] r, output logic [31:0] d);
    bus_we_i          = '0;
    bus_addr_i[p]     = a;
    bus_req_core_i[p] = r;
    #1;
    d = bus_rdata_o[p];
    @(negedge clk_i);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 4; m++) begin
        rd(0, a_clr(c, m), 2'(c), d);
        check({tag, " mailbox"}, d, mb[c][m]);
      end
      rd(1, a_ctl(c), 2'd0, d);
      check({tag, " ctrl"}, d, {28'b0, en[c]});
      rd(1, a_src(c), 2'd0, d);
      check({tag, " src"}, d, src_exp(c));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      nerr++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      en[c] = '0;
      for (int m = 0; m < 4; m++) mb[c][m] = '0;
    end
    irq_exp = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: reset state
    check("R2 irq after reset", {28'b0, irq_o}, 32'h0);
    check_all("R2");

    // R3 / R10: set each mailbox in turn, everything else untouched
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        put(0, a_set(c, m), (32'h1 << (c*4 + m)) | (32'h0101_0000 << m), 2'(m));
        step();
        check_all("R3 R10 set sweep");
      end
    // R3: OR into already-set bits, both ports merging on one mailbox
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        put(0, a_set(c, m), 32'hF000_0000 >> c, 2'd0);
        put(1, a_set(c, m), 32'h0000_0100 << m, 2'd1);
        step();
        rd(0, a_clr(c, m), 2'd0, d);
        check("R3 or-merge", d, mb[c][m]);
      end

    // R5: set address reads 0
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        rd(1, a_set(c, m), 2'd0, d);
        check("R5 set addr reads zero", d, 32'h0);
      end

    // empty one mailbox so an enabled-but-empty case exists
    put(0, a_clr(1, 2), 32'hFFFF_FFFF, 2'd1);
    step();

    // R6 / R7: every enable pattern on every core, upper write bits ignored
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 16; e++) begin
        put(0, a_ctl(c), {28'hDEADBEE, 4'(e)}, 2'd0);
        step();
        step();
        rd(1, a_ctl(c), 2'd0, d);
        check("R6 ctrl readback", d, {28'b0, 4'(e)});
        rd(1, a_src(c), 2'd0, d);
        check("R6 src pending", d, src_exp(c));
        check("R7 irq vs enable", {31'b0, irq_o[c]}, {31'b0, en[c] != 0 && src_exp(c) != 0});
      end
    for (int c = 0; c < 4; c++) begin
      put(0, a_ctl(c), 32'hF, 2'd0);
      step();
    end
    step();

    // R4: partial clear then full clear, irq falls
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        put(1, a_clr(c, m), 32'h0000_FFFF, 2'(c));
        step();
        rd(0, a_clr(c, m), 2'd0, d);
        check("R4 partial clear", d, mb[c][m]);
      end
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        put(0, a_clr(c, m), 32'hFFFF_FFFF, 2'd0);
        step();
      end
    step();
    check("R4 R7 irq low after clear", {28'b0, irq_o}, 32'h0);
    check_all("R4 all clear");

    // R8: set and clear collide on one mailbox, both port orders
    put(0, a_set(2, 1), 32'hFFFF_0000, 2'd2);
    step();
    put(0, a_set(2, 1), 32'h00FF_00FF, 2'd2);
    put(1, a_clr(2, 1), 32'h0F0F_0F0F, 2'd3);
    step();
    rd(0, a_clr(2, 1), 2'd0, d);
    check("R8 set beats clear", d, 32'hF0FF_00FF);
    put(1, a_set(3, 3), 32'h0000_00F0, 2'd0);
    put(0, a_clr(3, 3), 32'h0000_00FF, 2'd0);
    step();
    rd(0, a_clr(3, 3), 2'd0, d);
    check("R8 set beats clear swapped", d, 32'h0000_00F0);

    // R6: both ports write the same ctrl register, port 1 wins
    put(0, a_ctl(0), 32'h5, 2'd0);
    put(1, a_ctl(0), 32'hA, 2'd0);
    step();
    rd(0, a_ctl(0), 2'd0, d);
    check("R6 port1 priority", d, 32'hA);

    // R9: requester-relative alias
    for (int r = 0; r < 4; r++) begin
      put(1, 8'hC4, 32'h0 | (4'(r + 3)), 2'(r));
      step();
      rd(0, a_ctl(r), 2'd0, d);
      check("R9 alias ctrl write", d, {28'b0, 4'(r + 3)});
      rd(1, 8'hC4, 2'(r), d);
      check("R9 alias ctrl read", d, {28'b0, en[r]});
      rd(1, 8'hC0, 2'(r), d);
      check("R9 alias src read", d, src_exp(r));
    end

    // R10: doorbell multicast with core mask 4'b1011, vector 5
    for (int c = 0; c < 4; c++)
      if (c != 2) begin
        put(0, a_set(c, 0), 32'h1 << 5, 2'd0);
        step();
      end
    step();
    check_all("R10 doorbell multicast");

    // R1: unmapped / unaligned addresses read 0 and ignore writes
    put(0, 8'hC8, 32'hFFFF_FFFF, 2'd1);
    put(1, 8'h90, 32'hFFFF_FFFF, 2'd1);
    step();
    put(0, 8'h41, 32'hFFFF_FFFF, 2'd0);
    put(1, 8'h02, 32'hFFFF_FFFF, 2'd0);
    step();
    rd(0, 8'hC8, 2'd0, d);
    check("R1 unmapped read", d, 32'h0);
    rd(1, 8'h90, 2'd0, d);
    check("R1 pad read", d, 32'h0);
    check_all("R1 no side effect");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule